// File: doc/BRIEF.md
# Mode-Selected Address / General I/O Port

This block controls an eight-pin microcontroller port whose pins change role with the chip's operating mode. Each pin can carry one bit of the low byte of the external address bus, act as a plain input, or act as a general-purpose I/O with a programmable direction. A 3-bit mode code selects the behaviour. The internal address low byte arrives on its own input. A simple write strobe loads either the direction register or the output data register. The block drives per-pin output values and output enables toward the pads. It also presents a read value for the port.

In modes 1 and 3, all pins drive the address, whatever the direction register holds. In modes 5 and 6, each direction bit chooses between driving the matching address bit and acting as an input. In mode 7, the port is ordinary GPIO. The unlisted codes 0, 2 and 4 fall back to GPIO behaviour and raise a flag. Pad levels reach the read path through a two-stage synchronizer.

Top module: `addr_gpio_port`

## Requirements
- R1: In mode 1 or 3, pin_oe_o is all ones and pin_o[i] equals addr_i[i] for every i, whatever the direction register holds.
- R2: In mode 5 or 6, pin_oe_o[i] equals direction bit i. A pin with direction 1 drives addr_i[i].
- R3: In mode 7, pin_oe_o[i] equals direction bit i. A pin with direction 1 drives data register bit i.
- R4: Mode codes 0, 2 and 4 give the same pin and read behaviour as mode 7 and set illegal_mode_o to 1. Codes 1, 3, 5, 6 and 7 give illegal_mode_o = 0.
- R5: While rst_ni is low, the direction register, the data register and both synchronizer stages hold 0. Pins in modes 5, 6 and 7 are therefore inputs, and pins in modes 1 and 3 still drive the address.
- R6: A write with wr_en_i = 1 loads wr_data_i into the direction register when wr_sel_i = 0, or into the data register when wr_sel_i = 1. The write is accepted in any mode, and its effect on pin_oe_o and pin_o appears right after that clock edge.
- R7: rd_data_o[i] returns data register bit i for a GPIO-mode pin with direction 1, and addr_i[i] for a mode 5/6 pin with direction 1. Any other pin returns pin_i[i] as sampled two clock edges earlier. The direction register is never readable.
- R8: pin_o[i] is 0 whenever pin_oe_o[i] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode code |
| addr_i | input | 8 | Internal address low byte |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 direction, 1 data |
| wr_data_i | input | 8 | Write data |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables |
| rd_data_o | output | 8 | Port read value |
| illegal_mode_o | output | 1 | Mode code is not a defined one |

## Verification
The bench uses the default parameters: WIDTH = 8 and SYNC_STAGES = 2. With the full byte width, every direction bit can be set on its own, so a mode 5/6 or mode 7 mask that mixes address, input and output pins shows up in a single pattern. With two synchronizer stages, the read latency is short enough to check edge by edge, both in a directed transition and under random pin traffic that switches through all eight mode codes.

// File: rtl/port_pkg.sv
package port_pkg;
  typedef enum logic [1:0] {
    FN_ADDR_ALL = 2'd0,
    FN_ADDR_DIR = 2'd1,
    FN_GPIO     = 2'd2
  } port_fn_e;

  function automatic port_fn_e decode_mode(input logic [2:0] m);
    case (m)
      3'd1, 3'd3: return FN_ADDR_ALL;
      3'd5, 3'd6: return FN_ADDR_DIR;
      default:    return FN_GPIO;
    endcase
  endfunction

  function automatic logic mode_undefined(input logic [2:0] m);
    return (m == 3'd0) || (m == 3'd2) || (m == 3'd4);
  endfunction
endpackage

// File: rtl/port_regs.sv
module port_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] dat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      dat_o <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i) dat_o <= wr_data_i;
      else          dir_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/port_sync.sv
module port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/port_pin_mux.sv
module port_pin_mux
  import port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  port_fn_e         fn_i,
  input  logic [WIDTH-1:0] addr_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] dat_i,
  input  logic [WIDTH-1:0] sync_i,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] rd_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      unique case (fn_i)
        FN_ADDR_ALL: begin
          oe_o[i]  = 1'b1;
          out_o[i] = addr_i[i];
          rd_o[i]  = sync_i[i];
        end
        FN_ADDR_DIR: begin
          oe_o[i]  = dir_i[i];
          out_o[i] = dir_i[i] & addr_i[i];
          rd_o[i]  = dir_i[i] ? addr_i[i] : sync_i[i];
        end
        default: begin
          oe_o[i]  = dir_i[i];
          out_o[i] = dir_i[i] & dat_i[i];
          rd_o[i]  = dir_i[i] ? dat_i[i] : sync_i[i];
        end
      endcase
    end
  end
endmodule

// File: rtl/addr_gpio_port.sv
module addr_gpio_port
  import port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic [WIDTH-1:0] addr_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             illegal_mode_o
);
  port_fn_e         fn;
  logic [WIDTH-1:0] dir_q, dat_q, sync_q;

  assign fn             = decode_mode(mode_i);
  assign illegal_mode_o = mode_undefined(mode_i);

  port_regs #(.WIDTH(WIDTH)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .dir_o(dir_q), .dat_o(dat_q)
  );

  port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(sync_q)
  );

  port_pin_mux #(.WIDTH(WIDTH)) i_mux (
    .fn_i(fn), .addr_i, .dir_i(dir_q), .dat_i(dat_q), .sync_i(sync_q),
    .out_o(pin_o), .oe_o(pin_oe_o), .rd_o(rd_data_o)
  );
endmodule

// File: rtl/addr_gpio_port_chk.sv
module addr_gpio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode_i,
  input logic [WIDTH-1:0] addr_i,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [WIDTH-1:0] pin_i,
  input logic [WIDTH-1:0] pin_o,
  input logic [WIDTH-1:0] pin_oe_o,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             illegal_mode_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  AST_ADDR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd1 || mode_i == 3'd3) |-> (&pin_oe_o) && (pin_o == addr_i)); // R1
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && !wr_sel_i) && mode_i == 3'd7) |-> pin_oe_o == $past(wr_data_i)); // R6
  AST_DATA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && wr_sel_i) && mode_i == 3'd7) |-> (pin_o == ($past(wr_data_i) & pin_oe_o))); // R3
  AST_ADDR_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd5 || mode_i == 3'd6) |-> ((pin_o == (addr_i & pin_oe_o)) && ((rd_data_o & pin_oe_o) == (addr_i & pin_oe_o)))); // R2
  AST_NO_DRIVE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & ~pin_oe_o) == '0); // R8
  AST_ILLEGAL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_mode_o == (mode_i == 3'd0 || mode_i == 3'd2 || mode_i == 3'd4)); // R4
  AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && mode_i == 3'd1) |-> rd_data_o == $past(pin_i, 2)); // R7
endmodule

bind addr_gpio_port addr_gpio_port_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .addr_i(addr_i),
  .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
  .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
  .rd_data_o(rd_data_o), .illegal_mode_o(illegal_mode_o)
);

// File: tb/test_addr_gpio_port.sv
module test_addr_gpio_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   mode;
  logic [W-1:0] addr, wdata, pin_in;
  logic         wen, wsel;
  logic [W-1:0] pin_out, pin_oe, rd;
  logic         illegal;

  always #5 clk = ~clk;

  addr_gpio_port i_addr_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .addr_i(addr),
    .wr_en_i(wen), .wr_sel_i(wsel), .wr_data_i(wdata), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .rd_data_o(rd), .illegal_mode_o(illegal)
  );

  logic [W-1:0] m_dir, m_dat, m_s1, m_s2;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int fn_of(input logic [2:0] m);
    if (m == 3'd1 || m == 3'd3) return 0;
    if (m == 3'd5 || m == 3'd6) return 1;
    return 2;
  endfunction

  function automatic logic [W-1:0] exp_oe(input logic [2:0] m);
    return (fn_of(m) == 0) ? '1 : m_dir;
  endfunction

  function automatic logic [W-1:0] exp_out(input logic [2:0] m, input logic [W-1:0] a);
    case (fn_of(m))
      0:       return a;
      1:       return a & m_dir;
      default: return m_dat & m_dir;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_rd(input logic [2:0] m, input logic [W-1:0] a);
    case (fn_of(m))
      0:       return m_s2;
      1:       return (a & m_dir) | (m_s2 & ~m_dir);
      default: return (m_dat & m_dir) | (m_s2 & ~m_dir);
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (fn_of(m))
      0:       return "R1";
      1:       return "R2";
      default: return (m == 3'd7) ? "R3" : "R4";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    check(req_of(mode), "pin_oe", pin_oe, exp_oe(mode));
    check(req_of(mode), "pin_o", pin_out, exp_out(mode, addr));
    check("R7", "rd_data", rd, exp_rd(mode, addr));
    check("R8", "undriven pins low", pin_out & ~pin_oe, '0);
    check("R4", "illegal flag", {7'd0, illegal},
          {7'd0, (mode == 3'd0 || mode == 3'd2 || mode == 3'd4)});
  endtask

  task automatic cycle(input logic [2:0] m, input logic we, input logic sel,
                       input logic [W-1:0] wd, input logic [W-1:0] a, input logic [W-1:0] p);
    @(negedge clk);
    mode = m; wen = we; wsel = sel; wdata = wd; addr = a; pin_in = p;
    @(posedge clk);
    if (we) begin
      if (sel) m_dat = wd;
      else     m_dir = wd;
    end
    m_s2 = m_s1;
    m_s1 = p;
    #2;
    check_all();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; mode = 3'd7; addr = 8'h3c; wen = 0; wsel = 0; wdata = '0; pin_in = 8'hff;
    m_dir = '0; m_dat = '0; m_s1 = '0; m_s2 = '0;
    repeat (3) @(posedge clk);
    #2;
    // R5 reset state
    check("R5", "oe in reset mode7", pin_oe, 8'h00);
    check("R5", "rd in reset mode7", rd, 8'h00);
    mode = 3'd5; #1;
    check("R5", "oe in reset mode5", pin_oe, 8'h00);
    mode = 3'd1; #1;
    check("R5", "oe in reset mode1", pin_oe, 8'hff);
    check("R5", "pin in reset mode1", pin_out, 8'h3c);
    @(negedge clk);
    rst_n = 1; pin_in = '0;

    // R1 address ignores direction and data registers
    cycle(3'd1, 1, 0, 8'hff, 8'h5a, 8'h00);
    cycle(3'd3, 1, 1, 8'h0f, 8'ha5, 8'h00);
    check("R1", "mode3 addr output", pin_out, 8'ha5);
    // R6 data written in mode 3 shows in mode 7
    cycle(3'd7, 0, 0, 8'h00, 8'h00, 8'h00);
    check("R6", "data written earlier", pin_out, 8'h0f);
    // R6 direction write takes effect right after edge
    cycle(3'd7, 1, 0, 8'h3c, 8'h00, 8'h00);
    check("R6", "dir write oe", pin_oe, 8'h3c);
    check("R3", "gpio out", pin_out, 8'h0c);
    // R2 mixed mask in mode 5
    cycle(3'd5, 0, 0, 8'h00, 8'hf0, 8'h00);
    check("R2", "mode5 masked addr", pin_out, 8'h30);
    // R7 synchronizer latency, mode 1
    cycle(3'd1, 0, 0, 8'h00, 8'h00, 8'h00);
    cycle(3'd1, 0, 0, 8'h00, 8'h00, 8'h00);
    cycle(3'd1, 0, 0, 8'h00, 8'h00, 8'hff);
    check("R7", "one edge after change", rd, 8'h00);
    cycle(3'd1, 0, 0, 8'h00, 8'h00, 8'hff);
    check("R7", "two edges after change", rd, 8'hff);
    // R4 undefined codes follow mode 7
    cycle(3'd2, 0, 0, 8'h00, 8'h00, 8'h00);
    check("R4", "mode2 like mode7 oe", pin_oe, 8'h3c);
    cycle(3'd0, 0, 0, 8'h00, 8'h00, 8'h00);
    cycle(3'd4, 0, 0, 8'h00, 8'h00, 8'h00);

    for (int n = 0; n < 3000; n++) begin
      cycle(3'($urandom_range(0, 7)), ($urandom_range(0, 3) == 0), 1'($urandom),
            W'($urandom), W'($urandom), W'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule